// File: doc/BRIEF.md
# Descriptor Chain Walker for a DMA Channel

This block runs one DMA channel through a chain of buffers. Each buffer is described by a record of five words held in system memory. Software arms the channel by writing the address of the first record into the channel's pointer register. The walker then reads the record over a simple memory port, one word at a time, and loads the words into the channel registers. It then gives the buffer to a data-mover with a one-cycle start pulse.

When the data-mover reports completion, it also returns an updated first control word. The walker stores this word and writes it back into the record it came from. It then follows the record's next pointer. A zero next pointer ends the chain with a one-cycle completion pulse. A pointer that is not word-aligned ends the chain with a one-cycle error pulse, and no memory access is made at that pointer.

The channel registers are always visible on output ports. These ports also form the operand bus of the data-mover.

Top module: `lli_chain_seq`

## Requirements
- R1: A chain starts only when software writes a nonzero, word-aligned value to register index 2 (the next pointer) while the walker is idle. Writing zero there leaves `busy` low and makes no memory access. When the walker is idle, neither `mem_req` nor `mv_start` is ever high.
- R2: A record at base B holds five words. Index k sits at byte address B+4k: source is 0, destination 1, next pointer 2, control A 3, control B 4. The five words are read in ascending address order, with only one read request in flight at a time.
- R3: `mv_start` is a pulse of exactly one cycle. It follows the cycle in which the last (fifth) word is loaded. While it is high, `ch_src`, `ch_dst`, `ch_ctla` and `ch_ctlb` equal the fetched words.
- R4: Values that software wrote to the source, destination or control registers before a chain starts have no effect. The fetched record overwrites them.
- R5: On `mv_done`, control A takes the value of `mv_ctla_upd`. That value is then written to memory before any further read.
- R6: The write-back goes to the current record's base + 12, even though the pointer register already holds the next address. After the write-back, the walker fetches the record at the next pointer.
- R7: A zero next pointer raises `chain_done` for exactly one cycle. `busy` is low in the following cycle.
- R8: A misaligned pointer raises `align_err` for one cycle and returns the walker to idle with no memory access at that pointer. The pointer may come from software or from a fetched record. Misaligned means that bits 1:0 are nonzero.
- R9: While `busy` is high, configuration writes have no effect on the channel registers or on the chain.
- R10: A memory request keeps `mem_req` high and its address stable until `mem_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Software register write strobe |
| cfg_idx | input | 3 | Register index (0 src, 1 dst, 2 next, 3 ctl A, 4 ctl B) |
| cfg_wdata | input | W | Software write data |
| ch_src | output | W | Channel source address register |
| ch_dst | output | W | Channel destination address register |
| ch_next | output | W | Channel next-record pointer register |
| ch_ctla | output | W | Channel control A register |
| ch_ctlb | output | W | Channel control B register |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Byte address of the request |
| mem_wdata | output | W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| mv_start | output | 1 | One-cycle buffer start to the data-mover |
| mv_done | input | 1 | Data-mover completion pulse |
| mv_ctla_upd | input | W | Updated control A returned by the data-mover |
| busy | output | 1 | Chain in progress |
| chain_done | output | 1 | One-cycle end-of-chain pulse |
| align_err | output | 1 | One-cycle misaligned-pointer pulse |

## Verification
The bench builds the block with W = 32, so record words are 4 bytes apart and the write-back goes to offset 12. The bench's memory stalls one request in every three and varies read latency between zero and one extra cycles. This covers the hold rule and the one-read-in-flight rule. The chains used are laid out out of address order and end in a zero pointer, a misaligned fetched pointer, or a single record. Together they cover every exit path of the walker.

// File: rtl/lli_pkg.sv
package lli_pkg;

  localparam int DESC_WORDS = 5;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] WI_SRC = 3'd0;
  localparam logic [IDX_W-1:0] WI_DST = 3'd1;
  localparam logic [IDX_W-1:0] WI_NXT = 3'd2;
  localparam logic [IDX_W-1:0] WI_CTA = 3'd3;
  localparam logic [IDX_W-1:0] WI_CTB = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_KICK,
    ST_RUN,
    ST_WB_REQ,
    ST_NEXT
  } walk_state_e;

endpackage

// File: rtl/lli_desc_bank.sv
module lli_desc_bank
  import lli_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [W-1:0]     sw_data,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [W-1:0]     ld_data,
  input  logic             upd_we,
  input  logic [W-1:0]     upd_data,
  output logic [W-1:0]     q_src,
  output logic [W-1:0]     q_dst,
  output logic [W-1:0]     q_nxt,
  output logic [W-1:0]     q_cta,
  output logic [W-1:0]     q_ctb
);

  logic [W-1:0] word_q [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    localparam bit IS_CTA = (MY_IDX == WI_CTA);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (ld_we && ld_idx == MY_IDX) begin
        word_q[g] <= ld_data;
      end else if (IS_CTA && upd_we) begin
        word_q[g] <= upd_data;
      end else if (sw_we && sw_idx == MY_IDX) begin
        word_q[g] <= sw_data;
      end
    end
  end

  assign q_src = word_q[WI_SRC];
  assign q_dst = word_q[WI_DST];
  assign q_nxt = word_q[WI_NXT];
  assign q_cta = word_q[WI_CTA];
  assign q_ctb = word_q[WI_CTB];

endmodule

// File: rtl/lli_walk_fsm.sv
module lli_walk_fsm
  import lli_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [W-1:0]     sw_data,
  input  logic [W-1:0]     ptr_q,
  input  logic [W-1:0]     ctla_q,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [W-1:0]     mem_rdata,
  output logic             ld_we,
  output logic [IDX_W-1:0] ld_idx,
  output logic [W-1:0]     ld_data,
  output logic             upd_we,
  output logic [W-1:0]     upd_data,
  output logic             mv_start,
  input  logic             mv_done,
  input  logic [W-1:0]     mv_ctla_upd,
  output logic             busy,
  output logic             chain_done,
  output logic             align_err
);

  localparam int BYTES = W / 8;

  function automatic logic is_word_aligned(input logic [W-1:0] a);
    return (a & W'(BYTES - 1)) == '0;
  endfunction

  function automatic logic [W-1:0] word_addr(input logic [W-1:0] base,
                                             input logic [IDX_W-1:0] idx);
    return base + W'(idx) * W'(BYTES);
  endfunction

  walk_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     base_q, base_d;

  logic sw_ptr_wr, start_ok, sw_bad;
  logic at_next, next_zero, next_bad, next_go;

  assign sw_ptr_wr = sw_wr && (sw_idx == WI_NXT) && (state_q == ST_IDLE);
  assign start_ok  = sw_ptr_wr && (sw_data != '0) && is_word_aligned(sw_data);
  assign sw_bad    = sw_ptr_wr && (sw_data != '0) && !is_word_aligned(sw_data);

  assign at_next   = (state_q == ST_NEXT);
  assign next_zero = at_next && (ptr_q == '0);
  assign next_bad  = at_next && (ptr_q != '0) && !is_word_aligned(ptr_q);
  assign next_go   = at_next && (ptr_q != '0) && is_word_aligned(ptr_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_RD_REQ;
          idx_d   = WI_SRC;
          base_d  = sw_data;
        end
      end
      ST_RD_REQ:  if (mem_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (mem_rvalid) begin
          if (idx_q == WI_CTB) begin
            state_d = ST_KICK;
          end else begin
            idx_d   = idx_q + 3'd1;
            state_d = ST_RD_REQ;
          end
        end
      end
      ST_KICK:   state_d = ST_RUN;
      ST_RUN:    if (mv_done) state_d = ST_WB_REQ;
      ST_WB_REQ: if (mem_ready) state_d = ST_NEXT;
      ST_NEXT: begin
        if (next_go) begin
          state_d = ST_RD_REQ;
          idx_d   = WI_SRC;
          base_d  = ptr_q;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= WI_SRC;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
    end
  end

  assign mem_req   = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
  assign mem_we    = (state_q == ST_WB_REQ);
  assign mem_addr  = mem_we ? word_addr(base_q, WI_CTA) : word_addr(base_q, idx_q);
  assign mem_wdata = ctla_q;

  assign ld_we    = (state_q == ST_RD_WAIT) && mem_rvalid;
  assign ld_idx   = idx_q;
  assign ld_data  = mem_rdata;
  assign upd_we   = (state_q == ST_RUN) && mv_done;
  assign upd_data = mv_ctla_upd;

  assign mv_start   = (state_q == ST_KICK);
  assign busy       = (state_q != ST_IDLE);
  assign chain_done = next_zero;
  assign align_err  = sw_bad || next_bad;

endmodule

// File: rtl/lli_chain_seq.sv
module lli_chain_seq
  import lli_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [W-1:0]     cfg_wdata,
  output logic [W-1:0]     ch_src,
  output logic [W-1:0]     ch_dst,
  output logic [W-1:0]     ch_next,
  output logic [W-1:0]     ch_ctla,
  output logic [W-1:0]     ch_ctlb,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [W-1:0]     mem_rdata,
  output logic             mv_start,
  input  logic             mv_done,
  input  logic [W-1:0]     mv_ctla_upd,
  output logic             busy,
  output logic             chain_done,
  output logic             align_err
);

  logic             sw_we;
  logic             ld_we;
  logic [IDX_W-1:0] ld_idx;
  logic [W-1:0]     ld_data;
  logic             upd_we;
  logic [W-1:0]     upd_data;

  logic evt_last_word;
  logic evt_wb_fire;

  assign sw_we         = cfg_wr && !busy;
  assign evt_last_word = ld_we && (ld_idx == WI_CTB);
  assign evt_wb_fire   = mem_req && mem_we && mem_ready;

  lli_walk_fsm #(.W(W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_wr       (cfg_wr),
    .sw_idx      (cfg_idx),
    .sw_data     (cfg_wdata),
    .ptr_q       (ch_next),
    .ctla_q      (ch_ctla),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .ld_we       (ld_we),
    .ld_idx      (ld_idx),
    .ld_data     (ld_data),
    .upd_we      (upd_we),
    .upd_data    (upd_data),
    .mv_start    (mv_start),
    .mv_done     (mv_done),
    .mv_ctla_upd (mv_ctla_upd),
    .busy        (busy),
    .chain_done  (chain_done),
    .align_err   (align_err)
  );

  lli_desc_bank #(.W(W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sw_we),
    .sw_idx   (cfg_idx),
    .sw_data  (cfg_wdata),
    .ld_we    (ld_we),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data),
    .upd_we   (upd_we),
    .upd_data (upd_data),
    .q_src    (ch_src),
    .q_dst    (ch_dst),
    .q_nxt    (ch_next),
    .q_cta    (ch_ctla),
    .q_ctb    (ch_ctlb)
  );

endmodule

// File: rtl/lli_chain_sva.sv
module lli_chain_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_wr,
  input logic         busy,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_ready,
  input logic [W-1:0] mem_addr,
  input logic         mv_start,
  input logic         chain_done,
  input logic         align_err,
  input logic         evt_last_word,
  input logic         evt_wb_fire
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !mv_start)); // R1

  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_wr)); // R1

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> $past(evt_last_word)); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start); // R3

  AST_WB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wb_fire |-> busy); // R5

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !busy); // R7

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> (!mem_req && !busy)); // R8

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr % (W / 8)) == 0)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

endmodule

bind lli_chain_seq lli_chain_sva #(.W(W)) i_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mv_start      (mv_start),
  .chain_done    (chain_done),
  .align_err     (align_err),
  .evt_last_word (evt_last_word),
  .evt_wb_fire   (evt_wb_fire)
);

// File: tb/test_lli_chain_seq.sv
`timescale 1ns/1ps
module test_lli_chain_seq;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] ch_src, ch_dst, ch_next, ch_ctla, ch_ctlb;
  logic mem_req, mem_we;
  logic [W-1:0] mem_addr, mem_wdata;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [W-1:0] mem_rdata = '0;
  logic mv_start;
  logic mv_done = 1'b0;
  logic [W-1:0] mv_ctla_upd = '0;
  logic busy, chain_done, align_err;

  lli_chain_seq #(.W(W)) i_lli_chain_seq (.*);

  typedef struct {
    int          kind;  // 0 read, 1 write, 2 start
    logic [31:0] a, b, c, d;
  } ev_t;

  ev_t exp_q[$];
  logic [31:0] memw [0:511];
  int n_cmp = 0, n_bad = 0;
  int n_done = 0, n_err = 0, exp_done = 0, exp_err = 0;

  function automatic logic [31:0] mover_upd(input logic [31:0] c);
    return {c[31:16], c[31:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exv);
    end
  endtask

  // responder state
  int cyc = 0;
  bit acc_pend = 0, acc_we = 0;
  logic [31:0] acc_addr, acc_wdata;
  bit rd_pend = 0; int rd_wait = 0; logic [31:0] rd_data;
  bit mv_pend = 0; int mv_wait = 0; logic [31:0] mv_c;
  bit prev_done = 0, prev_stall = 0;
  logic [31:0] prev_addr;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rvalid = 1'b0;
      mv_done = 1'b0;
      if (rst_n) begin
        if (prev_stall)
          chk(mem_req && mem_addr == prev_addr, "R10 request held", mem_addr, prev_addr);
        if (acc_pend) begin
          acc_pend = 0;
          if (exp_q.size() == 0) begin
            chk(0, "R1 unexpected memory access", acc_addr, 32'h0);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            if (!acc_we) begin
              chk(e.kind == 0 && acc_addr == e.a, "R2 read order", acc_addr, e.a);
              rd_pend = 1; rd_wait = cyc % 2; rd_data = memw[acc_addr[10:2]];
            end else begin
              chk(e.kind == 1 && acc_addr == e.a, "R6 write-back address", acc_addr, e.a);
              chk(acc_wdata == e.b, "R5 write-back data", acc_wdata, e.b);
              memw[acc_addr[10:2]] = acc_wdata;
            end
          end
        end
        if (rd_pend) begin
          if (rd_wait == 0) begin
            mem_rvalid = 1'b1; mem_rdata = rd_data; rd_pend = 0;
          end else rd_wait--;
        end
        if (mv_start) begin
          ev_t e;
          if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected start", ch_src, 32'h0);
          end else begin
            e = exp_q.pop_front();
            chk(e.kind == 2, "R3 start position", e.kind, 2);
            chk(ch_src == e.a, "R4 source at start", ch_src, e.a);
            chk(ch_dst == e.b, "R4 destination at start", ch_dst, e.b);
            chk(ch_ctla == e.c, "R3 ctl A at start", ch_ctla, e.c);
            chk(ch_ctlb == e.d, "R3 ctl B at start", ch_ctlb, e.d);
          end
          mv_pend = 1; mv_wait = 2; mv_c = ch_ctla;
        end else if (mv_pend) begin
          if (mv_wait == 0) begin
            mv_done = 1'b1; mv_ctla_upd = mover_upd(mv_c); mv_pend = 0;
          end else mv_wait--;
        end
        if (!busy && (mem_req || mv_start))
          chk(0, "R1 activity while idle", {30'h0, mem_req, mv_start}, 32'h0);
        if (prev_done) chk(!busy, "R7 busy after end", busy, 0);
        prev_done = chain_done;
        if (chain_done) n_done++;
        if (align_err) n_err++;
        mem_ready = (cyc % 3) != 0;
        prev_stall = mem_req && !mem_ready;
        prev_addr = mem_addr;
        if (mem_req && mem_ready) begin
          acc_pend = 1; acc_we = mem_we; acc_addr = mem_addr; acc_wdata = mem_wdata;
        end
      end
    end
  end

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic make_desc(input logic [31:0] b, input logic [31:0] s,
                           input logic [31:0] dd, input logic [31:0] nx,
                           input logic [31:0] ca, input logic [31:0] cb);
    memw[b[10:2]] = s; memw[b[10:2]+1] = dd; memw[b[10:2]+2] = nx;
    memw[b[10:2]+3] = ca; memw[b[10:2]+4] = cb;
  endtask

  task automatic expect_chain(input logic [31:0] first);
    logic [31:0] p, nx;
    ev_t e;
    p = first; exp_done = 0; exp_err = 0; n_done = 0; n_err = 0;
    for (int k = 0; k < 8; k++) begin
      for (int w = 0; w < 5; w++) begin
        e.kind = 0; e.a = p + 32'(4 * w); e.b = 0; e.c = 0; e.d = 0;
        exp_q.push_back(e);
      end
      e.kind = 2; e.a = memw[p[10:2]]; e.b = memw[p[10:2]+1];
      e.c = memw[p[10:2]+3]; e.d = memw[p[10:2]+4];
      exp_q.push_back(e);
      e.kind = 1; e.a = p + 32'd12; e.b = mover_upd(memw[p[10:2]+3]); e.c = 0; e.d = 0;
      exp_q.push_back(e);
      nx = memw[p[10:2]+2];
      if (nx == 0) begin exp_done = 1; break; end
      if (nx[1:0] != 0) begin exp_err = 1; break; end
      p = nx;
    end
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic end_checks(input string tag);
    chk(exp_q.size() == 0, {tag, " all records walked"}, exp_q.size(), 0);
    chk(n_done == exp_done, "R7 chain_done pulses", n_done, exp_done);
    chk(n_err == exp_err, "R8 align_err pulses", n_err, exp_err);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) memw[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy && !mem_req && !mv_start, "R1 reset idle", busy, 0);
    chk(ch_src == 0 && ch_next == 0 && ch_ctla == 0, "R1 reset registers", ch_src, 0);

    // zero pointer write does nothing (R1)
    n_done = 0; n_err = 0;
    cfg_write(3'd2, 32'h0);
    repeat (6) @(negedge clk);
    chk(!busy, "R1 zero pointer no start", busy, 0);
    chk(n_err == 0 && n_done == 0, "R1 zero pointer no pulse", n_err, 0);

    // software preload, then three-record chain out of address order (R4, R5, R6, R9)
    cfg_write(3'd0, 32'hDEAD_0000);
    cfg_write(3'd1, 32'hDEAD_0001);
    cfg_write(3'd3, 32'hDEAD_0003);
    cfg_write(3'd4, 32'hDEAD_0004);
    @(negedge clk);
    chk(ch_src == 32'hDEAD_0000, "R4 software write landed", ch_src, 32'hDEAD_0000);
    make_desc(32'h100, 32'h1000, 32'h2000, 32'h180, 32'h0040_0001, 32'hB0);
    make_desc(32'h180, 32'h1100, 32'h2100, 32'h040, 32'h0080_0002, 32'hB1);
    make_desc(32'h040, 32'h1200, 32'h2200, 32'h000, 32'h0010_0003, 32'hB2);
    expect_chain(32'h100);
    cfg_write(3'd2, 32'h100);
    repeat (12) @(posedge clk);
    cfg_write(3'd0, 32'h5555_5555); // R9 ignored while busy
    cfg_write(3'd2, 32'h300);        // R9 no restart
    wait_idle();
    end_checks("R6");
    chk(memw[32'h10C >> 2] == 32'h0040_0040, "R5 memory after write-back",
        memw[32'h10C >> 2], 32'h0040_0040);
    chk(ch_src == 32'h1200, "R9 busy write ignored", ch_src, 32'h1200);
    chk(ch_ctla == 32'h0010_0010, "R5 ctl A takes update", ch_ctla, 32'h0010_0010);
    chk(ch_next == 32'h0, "R7 final pointer zero", ch_next, 0);

    // single record chain (R7)
    make_desc(32'h200, 32'h3000, 32'h4000, 32'h0, 32'h0007_0000, 32'hC0);
    expect_chain(32'h200);
    cfg_write(3'd2, 32'h200);
    wait_idle();
    end_checks("R2");

    // misaligned software pointer (R8)
    n_done = 0; n_err = 0;
    cfg_write(3'd2, 32'h102);
    repeat (5) @(negedge clk);
    chk(n_err == 1, "R8 software misaligned pulse", n_err, 1);
    chk(!busy, "R8 stays idle", busy, 0);

    // fetched misaligned next pointer (R8)
    make_desc(32'h240, 32'h5000, 32'h6000, 32'h2A1, 32'h0003_0009, 32'hD0);
    expect_chain(32'h240);
    cfg_write(3'd2, 32'h240);
    wait_idle();
    end_checks("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule